// File: doc/BRIEF.md
# Multi-Task Heartbeat Supervisor

This block stands between a set of monitored tasks and a system watchdog. It forwards a service pulse (a kick) to the watchdog only when every monitored task has shown signs of life during the last check interval. A single healthy task cannot keep the system alive while the others have stalled.

Each task owns one strobe input. In flag mode, a strobe sets that task's check-in flag. In counter mode, a strobe increments that task's saturating activity count. A programmable prescaler and an interval counter together set how often a check happens. At each check, the supervisor evaluates all tasks and then clears their state. In flag mode, a failed check only withholds the kick. In counter mode, every included task's count must lie inside its own programmed band. Any miss raises a sticky bite and records the lowest-numbered failing task.

Top module: `hb_supervisor`

## Requirements
- R1: A check happens once every (pre_div+1)*(iv_len+1) clock cycles, counted from reset release. A kick is a one-cycle pulse on `kick`, asserted in the cycle that follows the check.
- R2: When `mode_cnt` is 0 (flag mode), a kick is issued at a check if every task strobed at least once in the interval.
- R3: In flag mode, if any task did not strobe during the interval, there is no kick and `bite` stays 0.
- R4: Every check clears all flags and counts, whether the check passed or failed.
- R5: A strobe that arrives in the same cycle as a check is counted for the next interval, not for the one being checked.
- R6: When `mode_cnt` is 1 (counter mode), each strobe adds one to that task's count. A kick is issued if every included task's count satisfies lower <= count <= upper.
- R7: In counter mode, a failed check asserts `bite` in the cycle a kick would have appeared. `bite` then stays high until reset.
- R8: When the bite is raised, `fail_idx` captures the lowest-numbered failing task and holds that value until reset.
- R9: A count saturates at 2^CNT_W-1 and does not wrap.
- R10: A task whose lower and upper limits are both 0 is excluded from the counter-mode check.
- R11: Once `bite` is high, no further kicks are issued.
- R12: While `cfg_we` is 1, the task selected by `cfg_sel` loads `cfg_lo` and `cfg_hi` as its limits. Reset does not clear the limits.
- R13: While reset is held, `kick`, `bite` and `fail_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cnt | input | 1 | 0 = flag mode, 1 = counter mode; change only under reset |
| pre_div | input | PRE_W | Prescaler: one tick every pre_div+1 cycles |
| iv_len | input | IV_W | Check every iv_len+1 ticks |
| checkin | input | NUM_TASKS | One strobe per task |
| cfg_we | input | 1 | Limit write enable |
| cfg_sel | input | IDX_W | Task whose limits are written |
| cfg_lo | input | CNT_W | Lower limit value |
| cfg_hi | input | CNT_W | Upper limit value |
| kick | output | 1 | Watchdog service pulse |
| bite | output | 1 | Sticky failure flag (counter mode) |
| fail_idx | output | IDX_W | Lowest failing task at the bite |

## Verification
The bound checker checks the following rules on every cycle:
- A kick only ever follows a check.
- A bite only rises right after a check.
- Bite and fail index stay fixed until reset.
- No kick coexists with a bite.
- Flag mode never bites.

Other behaviours need the bench's scenarios. These include the band comparison, saturation, exclusion of tasks with zero limits, clearing at each check, attribution of a check-cycle strobe to the next interval, and choosing the lowest failing index. The bench drives counted strobe patterns per interval and predicts each check's outcome.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    MODE_FLAG  = 1'b0,
    MODE_COUNT = 1'b1
  } hb_mode_e;
endpackage

// File: rtl/hb_tick_gen.sv
module hb_tick_gen #(
  parameter int PRE_W = 16,
  parameter int IV_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [IV_W-1:0]  iv_len,
  output logic             check
);
  logic [PRE_W-1:0] pre_q;
  logic [IV_W-1:0]  iv_q;
  logic             tick;

  assign tick = (pre_q == pre_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      iv_q  <= '0;
      check <= 1'b0;
    end else begin
      check <= 1'b0;
      if (tick) begin
        pre_q <= '0;
        if (iv_q == iv_len) begin
          iv_q  <= '0;
          check <= 1'b1;
        end else begin
          iv_q <= iv_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_task_slot.sv
module hb_task_slot
  import hb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  hb_mode_e         mode,
  input  logic             strobe,
  input  logic             check,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic [CNT_W-1:0] cfg_hi,
  output logic             healthy
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             excluded;
  logic             in_band;

  // Limit storage: write-only port, no reset, so it survives a reset.
  always_ff @(posedge clk) begin
    if (cfg_wr) begin
      lo_q <= cfg_lo;
      hi_q <= cfg_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (check) begin
      // a strobe in the check cycle belongs to the next interval
      flag_q <= strobe;
      cnt_q  <= strobe ? CNT_W'(1) : '0;
    end else if (strobe) begin
      flag_q <= 1'b1;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign excluded = (lo_q == '0) && (hi_q == '0);
  assign in_band  = (cnt_q >= lo_q) && (cnt_q <= hi_q);

  always_comb begin
    if (mode == MODE_COUNT) healthy = excluded || in_band;
    else                    healthy = flag_q;
  end
endmodule

// File: rtl/hb_verdict.sv
module hb_verdict
  import hb_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hb_mode_e             mode,
  input  logic                 check,
  input  logic [NUM_TASKS-1:0] healthy,
  output logic                 kick,
  output logic                 bite,
  output logic [IDX_W-1:0]     fail_idx
);
  logic [IDX_W-1:0] first_bad;
  logic             any_bad;

  // priority encoder: lowest unhealthy task wins
  always_comb begin
    first_bad = '0;
    any_bad   = 1'b0;
    for (int i = NUM_TASKS - 1; i >= 0; i--) begin
      if (!healthy[i]) begin
        first_bad = IDX_W'(i);
        any_bad   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kick     <= 1'b0;
      bite     <= 1'b0;
      fail_idx <= '0;
    end else begin
      kick <= 1'b0;
      if (check && !bite) begin
        if (!any_bad) begin
          kick <= 1'b1;
        end else if (mode == MODE_COUNT) begin
          bite     <= 1'b1;
          fail_idx <= first_bad;
        end
      end
    end
  end
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 16,
  parameter int IV_W      = 16,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_cnt,
  input  logic [PRE_W-1:0]     pre_div,
  input  logic [IV_W-1:0]      iv_len,
  input  logic [NUM_TASKS-1:0] checkin,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [CNT_W-1:0]     cfg_lo,
  input  logic [CNT_W-1:0]     cfg_hi,
  output logic                 kick,
  output logic                 bite,
  output logic [IDX_W-1:0]     fail_idx
);
  hb_mode_e             mode;
  logic                 chk_pulse;
  logic [NUM_TASKS-1:0] slot_ok;

  assign mode = hb_mode_e'(mode_cnt);

  hb_tick_gen #(.PRE_W(PRE_W), .IV_W(IV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .pre_div (pre_div),
    .iv_len  (iv_len),
    .check   (chk_pulse)
  );

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_slot
    logic wr_here;
    assign wr_here = cfg_we && (cfg_sel == IDX_W'(g));
    hb_task_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode),
      .strobe  (checkin[g]),
      .check   (chk_pulse),
      .cfg_wr  (wr_here),
      .cfg_lo  (cfg_lo),
      .cfg_hi  (cfg_hi),
      .healthy (slot_ok[g])
    );
  end

  hb_verdict #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_verdict (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .check    (chk_pulse),
    .healthy  (slot_ok),
    .kick     (kick),
    .bite     (bite),
    .fail_idx (fail_idx)
  );
endmodule

// File: rtl/hb_supervisor_chk.sv
module hb_supervisor_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_cnt,
  input logic             check,
  input logic             kick,
  input logic             bite,
  input logic [IDX_W-1:0] fail_idx
);
  // R1: a kick only ever follows a check
  a_r1_kick_after_check: assert property (@(posedge clk) disable iff (rst)
    kick |-> $past(check));

  // R7: bite rises only right after a check
  a_r7_bite_on_check: assert property (@(posedge clk) disable iff (rst)
    $rose(bite) |-> $past(check));

  // R7: bite is sticky
  a_r7_bite_sticky: assert property (@(posedge clk) disable iff (rst)
    bite |=> bite);

  // R8: failing index held while bitten
  a_r8_idx_held: assert property (@(posedge clk) disable iff (rst)
    bite |=> $stable(fail_idx));

  // R11: no kick once bitten
  a_r11_no_kick_bitten: assert property (@(posedge clk) disable iff (rst)
    bite |-> !kick);

  // R3: flag mode never bites
  a_r3_flag_no_bite: assert property (@(posedge clk) disable iff (rst)
    !mode_cnt |-> !bite);
endmodule

bind hb_supervisor hb_supervisor_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_cnt (mode_cnt),
  .check    (chk_pulse),
  .kick     (kick),
  .bite     (bite),
  .fail_idx (fail_idx)
);

// File: tb/hb_supervisor_test.sv
module hb_supervisor_test;
  localparam int N = 4;
  localparam int L = 16;   // (pre_div+1)*(iv_len+1) = 2*8

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_cnt = 1'b0;
  logic [3:0] pre_div = 4'd1;
  logic [3:0] iv_len = 4'd7;
  logic [N-1:0] checkin = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [3:0] cfg_lo = '0, cfg_hi = '0;
  logic       kick, bite;
  logic [1:0] fail_idx;

  always #10 clk = ~clk;

  hb_supervisor #(.NUM_TASKS(N), .CNT_W(4), .PRE_W(4), .IV_W(4)) uut (
    .clk(clk), .rst(rst), .mode_cnt(mode_cnt), .pre_div(pre_div), .iv_len(iv_len),
    .checkin(checkin), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lo(cfg_lo),
    .cfg_hi(cfg_hi), .kick(kick), .bite(bite), .fail_idx(fail_idx));

  typedef struct { bit kick; bit bite; int idx; string req; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0, pc = 0;
  bit bitten = 0;
  int bite_idx = 0;
  int lo_m[N], hi_m[N];

  always @(posedge clk) pc <= rst ? 0 : pc + 1;

  // monitor: kick/bite are valid half a cycle after edge j*L
  always @(negedge clk) begin : mon
    exp_t e;
    if (pc > 1 && (pc % L) == 1) begin
      if (sb.size() != 0) begin
        e = sb.pop_front();
        n_chk++;
        if (kick !== e.kick || bite !== e.bite || (e.bite && fail_idx !== 2'(e.idx))) begin
          n_fail++;
          $display("FAIL %s: kick=%0b bite=%0b idx=%0d expected kick=%0b bite=%0b idx=%0d",
                   e.req, kick, bite, fail_idx, e.kick, e.bite, e.idx);
        end
      end
    end else if (pc > 0 && kick === 1'b1) begin
      n_chk++; n_fail++;
      $display("FAIL R1: kick=1 off the check slot at cycle %0d, expected kick=0", pc);
    end
  end

  task automatic start_reset(input bit m);
    @(negedge clk);
    rst = 1'b1; mode_cnt = m; checkin = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    n_chk++;   // R13 reset state
    if (kick !== 1'b0 || bite !== 1'b0 || fail_idx !== 2'd0) begin
      n_fail++;
      $display("FAIL R13: kick=%0b bite=%0b idx=%0d expected 0 0 0", kick, bite, fail_idx);
    end
    rst = 1'b0; bitten = 0; bite_idx = 0;
  endtask

  task automatic load_cfg(input int i, input int lo, input int hi);
    cfg_we = 1'b1; cfg_sel = 2'(i); cfg_lo = 4'(lo); cfg_hi = 4'(hi);
    @(negedge clk);
    cfg_we = 1'b0;
    lo_m[i] = lo; hi_m[i] = hi;
  endtask

  // driver: strobes per task in one interval, then predicts the check
  task automatic run_iv(input int c0, input int c1, input int c2, input int c3,
                        input int start, input string req);
    int c[N];
    exp_t e;
    bit any;
    int first;
    c = '{c0, c1, c2, c3};
    for (int t = 0; t < L; t++) begin
      for (int i = 0; i < N; i++) checkin[i] = (t >= start) && (t < start + c[i]);
      @(negedge clk);
    end
    any = 0; first = 0;
    for (int i = N - 1; i >= 0; i--) begin
      bit bad;
      int sat;
      sat = (c[i] > 15) ? 15 : c[i];
      if (mode_cnt) bad = !(lo_m[i] == 0 && hi_m[i] == 0) && (sat < lo_m[i] || sat > hi_m[i]);
      else          bad = (c[i] == 0);
      if (bad) begin any = 1; first = i; end
    end
    e.kick = !bitten && !any;
    if (mode_cnt && any && !bitten) begin bitten = 1; bite_idx = first; end
    e.bite = bitten; e.idx = bite_idx; e.req = req;
    sb.push_back(e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    // flag mode
    start_reset(1'b0); release_reset();
    run_iv(1, 1, 1, 1, 0,  "R1 R2");   // all check in
    run_iv(1, 1, 0, 1, 3,  "R3");      // task 2 silent
    run_iv(1, 1, 1, 1, 0,  "R5");      // strobes in check cycle of previous
    run_iv(0, 0, 0, 0, 0,  "R4");      // flags were cleared
    run_iv(2, 3, 1, 4, 12, "R2");      // late strobes
    // counter mode, limits loaded under reset
    start_reset(1'b1);
    load_cfg(0, 2, 5); load_cfg(1, 1, 3); load_cfg(2, 0, 0); load_cfg(3, 15, 15);
    release_reset();
    run_iv(3, 2, 0, 16, 0, "R9");      // 16 strobes saturate at 15
    run_iv(2, 1, 7, 15, 0, "R10");     // excluded task busy
    run_iv(5, 3, 0, 15, 0, "R6 R4");   // upper edges, counts cleared
    run_iv(6, 0, 0, 15, 0, "R7 R8");   // tasks 0 and 1 fail, lowest = 0
    run_iv(3, 2, 0, 15, 0, "R11");     // good counts but bitten
    start_reset(1'b1); release_reset();
    run_iv(3, 0, 0, 15, 0, "R8 R12");  // limits kept across reset
    start_reset(1'b1); release_reset();
    run_iv(3, 2, 0, 14, 0, "R8");      // task 3 below band
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule